// File: doc/BRIEF.md
# Configuration Image CRC Validator

This block fetches a configuration image stored as 16-bit words and decides whether the image is intact. The decision rests on an 8-bit CRC carried inside the image itself. After a start pulse it reads the image one word at a time through a request/response port. Each request carries a byte address. The block folds every word into a running CRC and compares the result with the checksum stored in the final word.

Images come in two sizes. The block first checks the image as a short one. If the checksum does not match, it reads the image again from word zero as a long image. If both attempts fail, it raises a flag that tells the surrounding logic to use a fallback configuration. Results are given with a one-cycle done pulse: a pass flag, which length matched, and the revision byte taken from the final word. These results stay unchanged until the next start.

Top module: `crcv_image_check`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `crc_ok`, `fallback_sel`, `long_used` and `req_valid` are 0 until a start is accepted.
- R2: Word k of a pass is requested at byte address `BASE_ADDR + 2*k`, with k counting up from 0 within each pass. While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R3: The CRC uses the polynomial x^8+x^7+x^6+x^4+x^2+1 in LSB-first form, so byte-table entry 1 is 0xF7 and entry 2 is 0xB9. The register starts at 0xFF and each byte step is crc = table[crc ^ byte]. Every word before the last feeds its low byte and then its high byte. The last word feeds only its low byte, and the result is then XORed with 0xFF. The stored checksum is bits [15:8] of the last word.
- R4: The first pass covers SHORT_WORDS words (default 64). If its checksum matches, the block reports `crc_ok`=1, `long_used`=0, `fallback_sel`=0 and `revision` = bits [7:0] of word SHORT_WORDS-1, and it makes no further reads.
- R5: If the short pass fails, the block starts a second pass from word 0 covering LONG_WORDS words (default 220). If that pass matches, it reports `crc_ok`=1, `long_used`=1, `fallback_sel`=0 and `revision` = bits [7:0] of word LONG_WORDS-1.
- R6: If both passes fail, the block reports `crc_ok`=0, `fallback_sel`=1, `long_used`=1 and `revision` = bits [7:0] of word LONG_WORDS-1.
- R7: `done` is high for exactly one cycle. It rises on the clock edge after the edge that accepts the final response. The result outputs change together with it and then hold their values until the next start.
- R8: A start pulse during a run has no effect. A response that arrives while no request is outstanding has no effect.
- R9: Only one request is outstanding at a time. After the request handshake, `req_valid` stays low until the response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a validation run (used only when idle) |
| req_valid | output | 1 | Word read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address of the requested word |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data word |
| done | output | 1 | One-cycle result strobe |
| crc_ok | output | 1 | Image checksum matched |
| fallback_sel | output | 1 | Both lengths failed; use fallback |
| long_used | output | 1 | Result came from the long-length pass |
| revision | output | 8 | Low byte of the final word read |

## Verification
Each address is due in the cycle the block raises `req_valid`. The memory model samples it at the falling edge before the accepting clock edge, and it answers a whole number of cycles later, also on a falling edge. `done` and the result fields are due one rising edge after the edge where the final response is taken. The monitor reads them at the next falling edge, and it checks at the falling edge after that that `done` has dropped. The values held on the outputs are checked again twenty cycles later, and the number of reads and done pulses for the run is compared with the expected count.

// File: rtl/crcv_pkg.sv
package crcv_pkg;

  // LSB-first form of x^8+x^7+x^6+x^4+x^2+1
  localparam logic [7:0] CRC_POLY_LSB = 8'hAB;
  localparam logic [7:0] CRC_SEED     = 8'hFF;
  localparam logic [7:0] CRC_XOROUT   = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2
  } seq_state_e;

  // One byte folded into the register, bit by bit
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_LSB) : (c >> 1);
    end
    return c;
  endfunction

  // A full word: low byte first, then high byte
  function automatic logic [7:0] crc8_word(input logic [7:0] crc, input logic [15:0] w);
    return crc8_byte(crc8_byte(crc, w[7:0]), w[15:8]);
  endfunction

endpackage

// File: rtl/crcv_addr_gen.sv
module crcv_addr_gen #(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0800,
  localparam int IDX_W = $clog2(LONG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              long_sel,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              is_last
);

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_WORDS - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_WORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign last_idx = long_sel ? LONG_LAST : SHORT_LAST;
  assign is_last  = (idx_q == last_idx);
  assign idx      = idx_q;
  assign addr     = BASE_ADDR + (ADDR_W'(idx_q) << 1);

  // R2: index never runs past the long image
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LONG_LAST);

  // R2: one step per accepted middle word
  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

// File: rtl/crcv_crc_acc.sv
module crcv_crc_acc
  import crcv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        feed,
  input  logic [15:0] word_in,
  output logic [7:0]  crc_state,
  output logic [7:0]  crc_final,
  output logic        crc_match
);

  logic [7:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (init) begin
      crc_q <= CRC_SEED;
    end else if (feed) begin
      crc_q <= crc8_word(crc_q, word_in);
    end
  end

  // Final word: only its low byte joins the checksum
  assign crc_final = crc8_byte(crc_q, word_in[7:0]) ^ CRC_XOROUT;
  assign crc_match = (crc_final == word_in[15:8]);
  assign crc_state = crc_q;

  // R3: register is reseeded whenever a pass restarts
  a_r3_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/crcv_seq.sv
module crcv_seq
  import crcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic       is_last,
  input  logic       crc_match,
  input  logic [7:0] last_lo,
  output logic       req_valid,
  output logic       restart,
  output logic       advance,
  output logic       long_sel,
  output logic       done,
  output logic       crc_ok,
  output logic       fallback_sel,
  output logic       long_used,
  output logic [7:0] revision
);

  seq_state_e state_q, state_d;
  logic       long_sel_q;
  logic       done_q, ok_q, fb_q, lu_q;
  logic [7:0] rev_q;

  // Named events
  logic accept_start, word_in, mid_word, last_word;
  logic pass_ok, retry, give_up;

  assign accept_start = (state_q == ST_IDLE) && start;
  assign word_in      = (state_q == ST_AWAIT) && rsp_valid;
  assign mid_word     = word_in && !is_last;
  assign last_word    = word_in && is_last;
  assign pass_ok      = last_word && crc_match;
  assign retry        = last_word && !crc_match && !long_sel_q;
  assign give_up      = last_word && !crc_match && long_sel_q;

  assign restart   = accept_start || retry;
  assign advance   = mid_word;
  assign req_valid = (state_q == ST_ISSUE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready) state_d = ST_AWAIT;
      ST_AWAIT: begin
        if (mid_word || retry)      state_d = ST_ISSUE;
        else if (pass_ok || give_up) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      long_sel_q <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      fb_q       <= 1'b0;
      lu_q       <= 1'b0;
      rev_q      <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= pass_ok || give_up;
      if (accept_start)  long_sel_q <= 1'b0;
      else if (retry)    long_sel_q <= 1'b1;
      if (accept_start) begin
        ok_q  <= 1'b0;
        fb_q  <= 1'b0;
        lu_q  <= 1'b0;
        rev_q <= '0;
      end else if (pass_ok) begin
        ok_q  <= 1'b1;
        fb_q  <= 1'b0;
        lu_q  <= long_sel_q;
        rev_q <= last_lo;
      end else if (give_up) begin
        ok_q  <= 1'b0;
        fb_q  <= 1'b1;
        lu_q  <= 1'b1;
        rev_q <= last_lo;
      end
    end
  end

  assign long_sel     = long_sel_q;
  assign done         = done_q;
  assign crc_ok       = ok_q;
  assign fallback_sel = fb_q;
  assign long_used    = lu_q;
  assign revision     = rev_q;

  // R4: every run opens with the short length
  a_r4_short_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (!long_sel_q && req_valid));

  // R5: a failed short pass goes straight into a long pass
  a_r5_retry_long: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> (long_sel_q && req_valid));

  // R8: start while busy leaves the state untouched
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_AWAIT && !rsp_valid) |=> (state_q == ST_AWAIT));

endmodule

// File: rtl/crcv_image_check.sv
module crcv_image_check #(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0800,
  localparam int IDX_W = $clog2(LONG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  output logic              done,
  output logic              crc_ok,
  output logic              fallback_sel,
  output logic              long_used,
  output logic [7:0]        revision
);

  logic             restart, advance, long_sel, is_last;
  logic             crc_match;
  logic [7:0]       crc_state, crc_final;
  logic [IDX_W-1:0] word_idx;

  crcv_addr_gen #(
    .SHORT_WORDS (SHORT_WORDS),
    .LONG_WORDS  (LONG_WORDS),
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR)
  ) addr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .advance  (advance),
    .long_sel (long_sel),
    .idx      (word_idx),
    .addr     (req_addr),
    .is_last  (is_last)
  );

  crcv_crc_acc crc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (restart),
    .feed      (advance),
    .word_in   (rsp_data),
    .crc_state (crc_state),
    .crc_final (crc_final),
    .crc_match (crc_match)
  );

  crcv_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .is_last      (is_last),
    .crc_match    (crc_match),
    .last_lo      (rsp_data[7:0]),
    .req_valid    (req_valid),
    .restart      (restart),
    .advance      (advance),
    .long_sel     (long_sel),
    .done         (done),
    .crc_ok       (crc_ok),
    .fallback_sel (fallback_sel),
    .long_used    (long_used),
    .revision     (revision)
  );

  // R2: a stalled request keeps its address
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R9: after a handshake no new request until the data returns
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R7: strobe is a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: strobe follows a taken response
  a_r7_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_valid));

  // R6: fallback only comes with a failed long pass
  a_r6_fallback_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_sel |-> (!crc_ok && long_used));

endmodule

// File: tb/crcv_image_check_tb.sv
module crcv_image_check_tb_top;

  localparam int S = 64;
  localparam int L = 220;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0800;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic          rsp_valid = 1'b0;
  logic [15:0]   rsp_data = '0;
  logic          done, crc_ok, fallback_sel, long_used;
  logic [7:0]    revision;

  always #2.5 clk = ~clk;  // 200 MHz

  crcv_image_check #(.SHORT_WORDS(S), .LONG_WORDS(L), .ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .crc_ok(crc_ok), .fallback_sel(fallback_sel),
    .long_used(long_used), .revision(revision)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference table built MSB-first on bit-reversed values
  logic [7:0] tbl [0:255];

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      c = rev8(8'(i));
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'hD5) : (c << 1);
      tbl[i] = rev8(c);
    end
  end

  logic [15:0] img [0:L-1];

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < n - 1; i++) begin
      c = tbl[c ^ img[i][7:0]];
      c = tbl[c ^ img[i][15:8]];
    end
    c = tbl[c ^ img[n-1][7:0]];
    return c ^ 8'hFF;
  endfunction

  typedef struct { bit ok; bit lng; bit fb; logic [7:0] rev; } exp_t;
  exp_t exp_q[$];
  exp_t last_exp;

  // Memory model state
  int  exp_idx = 0;
  int  pass_no = 0;
  int  reads = 0;
  int  addr_err = 0;
  int  lat_cfg = 0;
  int  tick = 0;
  bit  stray_go = 1'b0;
  bit  pend = 1'b0;
  int  dly = 0;
  int  pidx = 0;
  int  done_cnt = 0;

  initial begin : mem_model
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      tick++;
      req_ready = (tick % 4) != 2;
      if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = img[pidx];
          pend      = 1'b0;
        end else begin
          dly--;
        end
      end else if (stray_go) begin
        rsp_valid = 1'b1;
        rsp_data  = 16'hBEEF;
        stray_go  = 1'b0;
      end else if (req_valid && req_ready) begin
        if (req_addr !== AW'(int'(BASE) + 2 * exp_idx)) addr_err++;
        pidx = (int'(req_addr) - int'(BASE)) / 2;
        if (pidx < 0 || pidx >= L) pidx = 0;
        reads++;
        exp_idx++;
        if (pass_no == 0 && exp_idx == S) begin
          exp_idx = 0;
          pass_no = 1;
        end
        pend = 1'b1;
        dly  = lat_cfg;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk("R8 unexpected done", 32'd1, 32'd0);
        end else begin
          last_exp = exp_q.pop_front();
          chk("R3/R4/R5/R6 crc_ok", 32'(crc_ok), 32'(last_exp.ok));
          chk("R4/R5/R6 long_used", 32'(long_used), 32'(last_exp.lng));
          chk("R6 fallback_sel", 32'(fallback_sel), 32'(last_exp.fb));
          chk("R4/R5/R6 revision", 32'(revision), 32'(last_exp.rev));
        end
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 32'd0);
      end
    end
  end

  task automatic build_image(input int seed, input bit s_ok, input bit l_ok,
                             input logic [7:0] rs, input logic [7:0] rl, input bit ones);
    logic [7:0] c;
    for (int i = 0; i < L; i++)
      img[i] = ones ? 16'hFFFF : 16'((seed * 131 + i * 977) ^ (i << 5) ^ (seed << 9));
    img[S-1][7:0] = rs;
    c = ref_crc(S);
    img[S-1][15:8] = s_ok ? c : ~c;
    img[L-1][7:0] = rl;
    c = ref_crc(L);
    img[L-1][15:8] = l_ok ? c : (c ^ 8'h3C);
  endtask

  task automatic run_case(input string name, input int seed, input bit s_ok, input bit l_ok,
                          input logic [7:0] rs, input logic [7:0] rl, input bit ones,
                          input int lat, input bit dup_start);
    exp_t e;
    int base_done;
    int exp_reads;
    build_image(seed, s_ok, l_ok, rs, rl, ones);
    e.ok  = s_ok || l_ok;
    e.lng = !s_ok;
    e.fb  = !s_ok && !l_ok;
    e.rev = s_ok ? rs : rl;
    exp_reads = s_ok ? S : S + L;
    exp_q.push_back(e);
    exp_idx = 0; pass_no = 0; reads = 0; addr_err = 0; lat_cfg = lat;
    base_done = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (dup_start) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == base_done) @(negedge clk);
    repeat (20) @(negedge clk);
    $display("case %s finished", name);
    chk("R8 single done per run", 32'(done_cnt - base_done), 32'd1);
    chk("R4/R5 read count", 32'(reads), 32'(exp_reads));
    chk("R2 address sequence", 32'(addr_err), 32'd0);
    chk("R7 held crc_ok", 32'(crc_ok), 32'(e.ok));
    chk("R7 held revision", 32'(revision), 32'(e.rev));
    chk("R7 held fallback_sel", 32'(fallback_sel), 32'(e.fb));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: reset values while held and right after release
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 req_valid in reset", 32'(req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 crc_ok after reset", 32'(crc_ok), 32'd0);
    chk("R1 fallback after reset", 32'(fallback_sel), 32'd0);
    chk("R1 long_used after reset", 32'(long_used), 32'd0);
    chk("R1 req_valid after reset", 32'(req_valid), 32'd0);
    // R3: table anchors
    chk("R3 table entry 1", 32'(tbl[1]), 32'hF7);
    chk("R3 table entry 2", 32'(tbl[2]), 32'hB9);

    run_case("short ok",       3,  1'b1, 1'b0, 8'h02, 8'h77, 1'b0, 0, 1'b0);
    run_case("long ok",        7,  1'b0, 1'b1, 8'h11, 8'h08, 1'b0, 1, 1'b0);
    run_case("both bad",       11, 1'b0, 1'b0, 8'h05, 8'h04, 1'b0, 2, 1'b0);
    run_case("ones short ok",  0,  1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 0, 1'b0);
    run_case("ones both bad",  0,  1'b0, 1'b0, 8'h33, 8'hC4, 1'b1, 1, 1'b0);

    // R8: start pulses during a run are ignored
    run_case("dup start long", 21, 1'b0, 1'b1, 8'h09, 8'h05, 1'b0, 1, 1'b1);

    // R8: stray response while idle changes nothing
    stray_go = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 stray no done", 32'(done), 32'd0);
    chk("R8 stray keeps crc_ok", 32'(crc_ok), 32'd1);
    chk("R8 stray keeps revision", 32'(revision), 32'h05);
    chk("R8 stray no request", 32'(req_valid), 32'd0);

    run_case("after stray",    42, 1'b1, 1'b0, 8'h03, 8'h01, 1'b0, 3, 1'b0);

    repeat (5) @(negedge clk);
    chk("R8 no pending expectations", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule